// File: doc/BRIEF.md
# Two-Step Power-Down Entry Sequencer

This block stands between a CPU's control-register write port and the power-management logic. It turns a deliberate pair of register writes into one power-down request. The CPU marks each completed instruction with a boundary strobe. Any register write that the instruction performs is presented on the write port in that same cycle.

Entry takes two writes to the control address, in two instructions that follow each other with nothing in between. The first write sets the enable bit and leaves the start bit clear. The second write sets the start bit. Both bits clear themselves. The enable bit lasts only until the next boundary. The start bit lasts one cycle, and the request is latched in that cycle. After that, the request output stays high and the block ignores all further strobes until hardware reset. Oscillator gating, pin floating and the CPU pipeline are outside this block.

Top module: `pwrdn_entry_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the enable bit, the start bit and the request output all read 0.
- R2: A boundary whose write targets the control address with the enable bit (default position 1) at 1 and the start bit (default position 0) at 0 makes the enable bit read 1 from the next cycle.
- R3: A boundary whose write to the control address sets both the enable and the start bit does not arm the sequence. If the sequence was not armed, all three outputs stay 0.
- R4: If the boundary after an arming write does not carry a start write, the enable bit reads 0 after it. An arming write in that position arms the sequence again.
- R5: A start write at the boundary directly after an arming write makes the start bit read 1 for exactly one cycle. In the following cycle the request output reads 1 and the start bit reads 0.
- R6: Any other completed instruction between the arming write and the start write drops the armed state. This includes an instruction with no write and a write to another address. The later start write then has no effect.
- R7: A start write at a boundary with the sequence not armed has no effect on any output.
- R8: Once the request is high, strobes and writes have no effect: the enable and start bits stay 0, even after an arming write. The same holds for a strobe in the cycle in which the start bit is high.
- R9: The request output stays high until hardware reset, and reset clears it.
- R10: A write without a boundary strobe is ignored. The armed state holds across cycles that have no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| instr_done_i | input | 1 | Instruction-boundary strobe, one cycle per completed instruction |
| wr_en_i | input | 1 | The completing instruction writes a register |
| wr_addr_i | input | ADDR_W | Register address of that write |
| wr_data_i | input | DATA_W | Data of that write |
| en_bit_o | output | 1 | Readable enable (arm) bit |
| start_bit_o | output | 1 | Readable start bit |
| pd_req_o | output | 1 | Power-down request level |

## Verification
The bench overrides the defaults. It moves the control address to 8'hA5, places the enable bit at position 6 and the start bit at position 5. This shows that decoding follows the parameters and not fixed bit positions. It also leaves the low data bits free, so a write with only low bits set can serve as a no-op write to the control address. With these values the bench reaches the arm-then-start path, arming followed by a write with no instruction between, re-arming, and the both-bits write. It also reaches idle gaps in the middle of the sequence and the sticky request that only reset clears.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

   typedef enum logic [1:0] {
      SLOT_OTHER = 2'd0,
      SLOT_ARM   = 2'd1,
      SLOT_START = 2'd2
   } slot_kind_e;

   typedef struct packed {
      logic en;
      logic st;
      logic pd;
   } seq_state_t;

endpackage

// File: rtl/pds_wr_decode.sv
module pds_wr_decode
   import pwrdn_pkg::*;
#(
   parameter int unsigned     ADDR_W    = 8,
   parameter int unsigned     DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h87,
   parameter logic [ADDR_W-1:0] ADDR_MASK = '1,
   parameter int unsigned     EN_POS    = 1,
   parameter int unsigned     ST_POS    = 0
) (
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output slot_kind_e        kind_o
);

   localparam logic [ADDR_W-1:0] MATCH_VAL = CTRL_ADDR & ADDR_MASK;
   localparam bit                FULL_CMP  = (ADDR_MASK == {ADDR_W{1'b1}});

   logic addr_hit;

   generate
      if (FULL_CMP) begin : g_full
         assign addr_hit = (wr_addr_i == CTRL_ADDR);
      end else begin : g_masked
         assign addr_hit = ((wr_addr_i & ADDR_MASK) == MATCH_VAL);
      end
   endgenerate

   logic hit;
   assign hit = wr_en_i & addr_hit;

   always_comb begin
      kind_o = SLOT_OTHER;
      if (hit && wr_data_i[ST_POS]) begin
         kind_o = SLOT_START;
      end else if (hit && wr_data_i[EN_POS]) begin
         kind_o = SLOT_ARM;
      end
   end

endmodule

// File: rtl/pds_arm_track.sv
module pds_arm_track
   import pwrdn_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slot_i,
   input  slot_kind_e kind_i,
   output seq_state_t state_o
);

   seq_state_t st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else if (st_q.pd) begin
         st_q.en <= 1'b0;
         st_q.st <= 1'b0;
      end else if (st_q.st) begin
         st_q.pd <= 1'b1;
         st_q.st <= 1'b0;
         st_q.en <= 1'b0;
      end else if (slot_i) begin
         unique case (kind_i)
            SLOT_ARM: begin
               st_q.en <= 1'b1;
            end
            SLOT_START: begin
               st_q.st <= st_q.en;
               st_q.en <= 1'b0;
            end
            default: begin
               st_q.en <= 1'b0;
            end
         endcase
      end
   end

   assign state_o = st_q;

endmodule

// File: rtl/pwrdn_entry_seq.sv
module pwrdn_entry_seq
   import pwrdn_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h87,
   parameter logic [ADDR_W-1:0] ADDR_MASK = '1,
   parameter int unsigned       EN_POS    = 1,
   parameter int unsigned       ST_POS    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_done_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              en_bit_o,
   output logic              start_bit_o,
   output logic              pd_req_o
);

   generate
      if (EN_POS >= DATA_W) begin : g_bad_en
         $error("enable bit position outside data width");
      end
      if (ST_POS >= DATA_W) begin : g_bad_st
         $error("start bit position outside data width");
      end
      if (EN_POS == ST_POS) begin : g_bad_same
         $error("enable and start bits must differ");
      end
      if (ADDR_W < 1) begin : g_bad_aw
         $error("address width must be at least 1");
      end
   endgenerate

   slot_kind_e kind;
   seq_state_t state;

   pds_wr_decode #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CTRL_ADDR(CTRL_ADDR),
      .ADDR_MASK(ADDR_MASK),
      .EN_POS   (EN_POS),
      .ST_POS   (ST_POS)
   ) dec_i (
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .kind_o   (kind)
   );

   pds_arm_track trk_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .slot_i (instr_done_i),
      .kind_i (kind),
      .state_o(state)
   );

   assign en_bit_o    = state.en;
   assign start_bit_o = state.st;
   assign pd_req_o    = state.pd;

endmodule

// File: rtl/pwrdn_entry_seq_chk.sv
module pwrdn_entry_seq_chk #(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h87,
   parameter int unsigned       EN_POS    = 1,
   parameter int unsigned       ST_POS    = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_done_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic              en_bit_o,
   input logic              start_bit_o,
   input logic              pd_req_o
);

   logic arm_wr;
   assign arm_wr = instr_done_i && wr_en_i && (wr_addr_i == CTRL_ADDR)
                   && wr_data_i[EN_POS] && !wr_data_i[ST_POS];

   // R4: without a fresh arming write, a boundary ends the armed state
   assert_en_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en_bit_o && instr_done_i && !arm_wr |=> !en_bit_o);

   // R10: the armed state holds while no boundary occurs
   assert_arm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      en_bit_o && !instr_done_i && !pd_req_o |=> en_bit_o);

   // R5: the start bit lasts one cycle and then the request is latched
   assert_start_to_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_bit_o |=> pd_req_o && !start_bit_o);

   assert_excl_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({en_bit_o, start_bit_o, pd_req_o}));

   // R7: the start bit only rises after the sequence was armed
   assert_start_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_bit_o) |-> $past(en_bit_o));

   // R9: the request is sticky
   assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pd_req_o |=> pd_req_o);

   // R8: while the request is high, writes cannot set the bits
   assert_req_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pd_req_o |=> !en_bit_o && !start_bit_o);

endmodule

bind pwrdn_entry_seq pwrdn_entry_seq_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CTRL_ADDR(CTRL_ADDR),
   .EN_POS   (EN_POS),
   .ST_POS   (ST_POS)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_done_i(instr_done_i),
   .wr_en_i     (wr_en_i),
   .wr_addr_i   (wr_addr_i),
   .wr_data_i   (wr_data_i),
   .en_bit_o    (en_bit_o),
   .start_bit_o (start_bit_o),
   .pd_req_o    (pd_req_o)
);

// File: tb/pwrdn_entry_seq_tb_top.sv
`timescale 1ns/1ps
module pwrdn_entry_seq_tb_top;

   localparam logic [7:0] CTRL  = 8'hA5;
   localparam logic [7:0] OTHER = 8'h3C;
   localparam logic [7:0] D_EN  = 8'h40;   // enable bit at position 6
   localparam logic [7:0] D_ST  = 8'h20;   // start bit at position 5
   localparam logic [7:0] D_BTH = 8'h60;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       instr_done = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       en_bit, start_bit, pd_req;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwrdn_entry_seq #(
      .ADDR_W(8), .DATA_W(8), .CTRL_ADDR(8'hA5), .EN_POS(6), .ST_POS(5)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .instr_done_i(instr_done),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .en_bit_o(en_bit), .start_bit_o(start_bit), .pd_req_o(pd_req)
   );

   task automatic check(string req, logic [2:0] exp);
      logic [2:0] act;
      act = {en_bit, start_bit, pd_req};
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {en,start,req} actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      instr_done = 1'b0;
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic instr(logic we, logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      instr_done = 1'b1;
      wr_en = we;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      instr_done = 1'b0;
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_R1();
      @(negedge clk);
      rst_n = 1'b0;
      check("R1", 3'b000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 3'b000);
   endtask

   task automatic t_arm_start_R2_R5();
      do_reset();
      instr(1'b1, CTRL, D_EN);
      check("R2", 3'b100);
      instr(1'b1, CTRL, D_ST);
      check("R5", 3'b010);
      idle(1);
      check("R5", 3'b001);
   endtask

   task automatic t_both_R3();
      do_reset();
      instr(1'b1, CTRL, D_BTH);
      check("R3", 3'b000);
      instr(1'b1, CTRL, D_ST);
      check("R3", 3'b000);
   endtask

   task automatic t_selfclear_R4();
      do_reset();
      instr(1'b1, CTRL, D_EN);
      instr(1'b1, CTRL, 8'h01);
      check("R4", 3'b000);
      instr(1'b1, CTRL, D_EN);
      instr(1'b1, CTRL, D_EN);
      check("R4", 3'b100);
      instr(1'b1, CTRL, D_ST);
      check("R4", 3'b010);
   endtask

   task automatic t_gap_R6();
      do_reset();
      instr(1'b1, CTRL, D_EN);
      instr(1'b0, CTRL, 8'h00);
      check("R6", 3'b000);
      instr(1'b1, CTRL, D_ST);
      idle(1);
      check("R6", 3'b000);
      instr(1'b1, CTRL, D_EN);
      instr(1'b1, OTHER, D_ST);
      check("R6", 3'b000);
      instr(1'b1, CTRL, D_ST);
      idle(1);
      check("R6", 3'b000);
   endtask

   task automatic t_unarmed_R7();
      do_reset();
      instr(1'b1, CTRL, D_ST);
      check("R7", 3'b000);
      idle(2);
      check("R7", 3'b000);
   endtask

   task automatic t_sticky_R8_R9();
      do_reset();
      instr(1'b1, CTRL, D_EN);
      instr(1'b1, CTRL, D_ST);
      instr(1'b1, CTRL, D_EN);
      check("R8", 3'b001);
      instr(1'b1, CTRL, D_EN);
      check("R8", 3'b001);
      instr(1'b1, CTRL, D_ST);
      idle(3);
      check("R9", 3'b001);
      do_reset();
      check("R9", 3'b000);
   endtask

   task automatic t_nostrobe_R10();
      do_reset();
      @(negedge clk);
      wr_en = 1'b1; wr_addr = CTRL; wr_data = D_EN;
      @(negedge clk);
      wr_en = 1'b0;
      check("R10", 3'b000);
      instr(1'b1, CTRL, D_EN);
      idle(5);
      check("R10", 3'b100);
      instr(1'b1, CTRL, D_ST);
      idle(1);
      check("R10", 3'b001);
   endtask

   initial begin
      t_reset_R1();
      t_arm_start_R2_R5();
      t_both_R3();
      t_selfclear_R4();
      t_gap_R6();
      t_unarmed_R7();
      t_sticky_R8_R9();
      t_nostrobe_R10();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule